// File: doc/BRIEF.md
# Multi-Source Reset Supervisor with Release Stretching

This block merges four reset requests into one internal reset: a power-on comparator flag, an active-low external reset pin, a watchdog expiry pulse and a brown-out comparator flag. As soon as any qualified request is active, both the port-level reset and the internal reset assert. This path is combinational or uses an asynchronous set, so no clock edge is needed. The internal reset stays asserted after the last request has gone away. It is held for a stretch period whose length is chosen by a small select input, which lets the supply and clocks settle before logic starts to run.

Two of the requests are qualified before they count. The watchdog only resets the chip when it is enabled and is not in interrupt mode. The brown-out flag only counts when its detector is enabled. The external pin is first synchronised and then filtered, so that short spikes are rejected.

A four-bit cause register records why the chip was reset. Software reads it on a plain register bus and clears individual bits by writing zeros. The register survives every reset except power-on.

Top module: `reset_supervisor`

## Requirements
- R1: Each of the four qualified sources (power-on flag high, filtered external pin, qualified watchdog expiry, qualified brown-out) drives `sys_rst_n_o` and `port_rst_n_o` low.
- R2: `port_rst_n_o` follows the qualified sources with no clock edge. `sys_rst_n_o` is asserted no later than `port_rst_n_o`, in the same time step, through an asynchronous set.
- R3: Once every source is inactive, `sys_rst_n_o` rises on the N-th rising clock edge, where N = BASE_CYC << `dly_sel_i` (4, 8, 16 or 32 with the default parameters).
- R4: A source that reasserts during the stretch count restarts the count. The full N edges are counted again from its release.
- R5: The external pin passes a two-flop synchroniser and a filter. A low pulse counts only if it lasts at least MIN_W clock cycles (default 4). Shorter pulses cause no reset and set no flag. After a qualifying pulse, `sys_rst_n_o` rises N+3 edges after the pin returns high.
- R6: A watchdog expiry pulse resets the block only when `wdt_en_i` is 1 and `wdt_irq_mode_i` is 0. Otherwise it has no effect on the resets or the flags.
- R7: A brown-out low-supply flag resets the block only when `bod_en_i` is 1. Otherwise it has no effect.
- R8: The cause bits are [0] power-on, [1] external, [2] brown-out and [3] watchdog. A power-on reset forces the value 4'b0001. Every other source sets only its own bit, one edge after it is qualified, and the other bits are left unchanged.
- R9: `reg_rdata_o` always shows the cause bits. A write with `reg_wr_i` high clears each bit whose write-data bit is 0; a 1 in the write data leaves that bit unchanged.
- R10: If a source sets a bit on the same edge that a write clears it, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for the filter, the stretch counter and the register |
| por_flag_i | input | 1 | Supply below the power-on threshold (active high, asynchronous) |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_expire_i | input | 1 | Watchdog period expired, one-cycle pulse |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_irq_mode_i | input | 1 | Watchdog in interrupt mode (no reset) |
| bod_low_i | input | 1 | Supply below the brown-out threshold |
| bod_en_i | input | 1 | Brown-out detector enabled |
| dly_sel_i | input | SEL_W | Stretch delay select |
| reg_wr_i | input | 1 | Cause register write strobe |
| reg_wdata_i | input | 4 | Write data; 0 bits clear the matching flags |
| reg_rdata_o | output | 4 | Cause flags |
| sys_rst_n_o | output | 1 | Stretched internal reset, active low |
| port_rst_n_o | output | 1 | Immediate port reset, active low |

## Verification
The two functions that can meet on one edge are a source setting its cause bit and a software write that clears bits. The bench lines up a qualified watchdog pulse with a write of all zeros in the same cycle. It expects the watchdog bit to survive while the write still clears an older brown-out bit. A second collision is a source that reasserts in the middle of a stretch count. The bench judges it by counting edges from the final release and expecting the full delay again, not the remainder.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;
  localparam int CAUSE_W = 4;
  localparam int C_POR = 0;
  localparam int C_EXT = 1;
  localparam int C_BOD = 2;
  localparam int C_WDT = 3;

  // stretch length in clock edges for a given select value
  function automatic int unsigned stretch_len(input int unsigned base, input int unsigned sel);
    return base << sel;
  endfunction

  // counter width able to hold value v
  function automatic int unsigned width_for(input int unsigned v);
    return $clog2(v + 1);
  endfunction
endpackage

// File: rtl/rstsup_pin_filter.sv
module rstsup_pin_filter #(
  parameter int MIN_W = 4
) (
  input  logic clk,
  input  logic arst,
  input  logic pin_n,
  output logic hit_o
);
  localparam int CW = rstsup_pkg::width_for(MIN_W);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          pin_low_s;

  assign pin_low_s = ~sync_q[1];

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_n};
      if (pin_low_s) begin
        if (cnt_q != CW'(MIN_W)) cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign hit_o = (cnt_q == CW'(MIN_W));

  // R5
  filt_min_width_chk: assert property (@(posedge clk) disable iff (arst)
    $rose(hit_o) |-> ($past(cnt_q) == CW'(MIN_W - 1)));

  // R5
  filt_drop_chk: assert property (@(posedge clk) disable iff (arst)
    !pin_low_s |=> !hit_o);
endmodule

// File: rtl/rstsup_stretch.sv
module rstsup_stretch #(
  parameter int BASE_CYC = 4,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             src_any,
  input  logic [SEL_W-1:0] dly_sel,
  output logic             rst_act_o
);
  localparam int unsigned MAX_LEN = rstsup_pkg::stretch_len(BASE_CYC, (1 << SEL_W) - 1);
  localparam int CNT_W = rstsup_pkg::width_for(MAX_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             rst_q;

  assign last_cnt = CNT_W'(rstsup_pkg::stretch_len(BASE_CYC, int'(dly_sel)) - 1);

  always_ff @(posedge clk or posedge src_any) begin
    if (src_any) begin
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else if (rst_q) begin
      if (cnt_q == last_cnt) rst_q <= 1'b0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_act_o = rst_q;

  // R3
  stretch_bound_chk: assert property (@(posedge clk) disable iff (src_any)
    rst_q |-> (cnt_q <= last_cnt));

  // R3
  stretch_release_chk: assert property (@(posedge clk) disable iff (src_any)
    $fell(rst_q) |-> ($past(cnt_q) == $past(last_cnt)));

  // R4
  stretch_restart_chk: assert property (@(posedge clk)
    src_any |-> (rst_q && cnt_q == '0));
endmodule

// File: rtl/rstsup_cause_reg.sv
module rstsup_cause_reg (
  input  logic                            clk,
  input  logic                            por,
  input  logic [rstsup_pkg::CAUSE_W-1:0]  set_vec,
  input  logic                            wr,
  input  logic [rstsup_pkg::CAUSE_W-1:0]  wdata,
  output logic [rstsup_pkg::CAUSE_W-1:0]  flags_o
);
  import rstsup_pkg::*;

  localparam logic [CAUSE_W-1:0] POR_VAL = CAUSE_W'(1) << C_POR;

  logic [CAUSE_W-1:0] flags_q;
  logic [CAUSE_W-1:0] keep_mask;

  assign keep_mask = wr ? wdata : '1;

  always_ff @(posedge clk or posedge por) begin
    if (por) flags_q <= POR_VAL;
    else     flags_q <= (flags_q & keep_mask) | set_vec;
  end

  assign flags_o = flags_q;

  // R9
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (por)
    ((flags_q & ~$past(flags_q) & ~$past(set_vec)) == '0));

  // R9
  zero_clears_chk: assert property (@(posedge clk) disable iff (por)
    wr |=> ((flags_q & ~$past(wdata) & ~$past(set_vec)) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (por)
    1'b1 |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int MIN_W    = 4,
  parameter int BASE_CYC = 4,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             por_flag_i,
  input  logic             ext_rst_n_i,
  input  logic             wdt_expire_i,
  input  logic             wdt_en_i,
  input  logic             wdt_irq_mode_i,
  input  logic             bod_low_i,
  input  logic             bod_en_i,
  input  logic [SEL_W-1:0] dly_sel_i,
  input  logic             reg_wr_i,
  input  logic [3:0]       reg_wdata_i,
  output logic [3:0]       reg_rdata_o,
  output logic             sys_rst_n_o,
  output logic             port_rst_n_o
);
  import rstsup_pkg::*;

  logic ext_hit;
  logic wdt_hit;
  logic bod_hit;
  logic src_any;
  logic rst_act;
  logic [CAUSE_W-1:0] set_vec;

  rstsup_pin_filter #(.MIN_W(MIN_W)) u_filter (
    .clk   (clk),
    .arst  (por_flag_i),
    .pin_n (ext_rst_n_i),
    .hit_o (ext_hit)
  );

  assign wdt_hit = wdt_expire_i & wdt_en_i & ~wdt_irq_mode_i;
  assign bod_hit = bod_low_i & bod_en_i;
  assign src_any = por_flag_i | ext_hit | wdt_hit | bod_hit;

  rstsup_stretch #(.BASE_CYC(BASE_CYC), .SEL_W(SEL_W)) u_stretch (
    .clk       (clk),
    .src_any   (src_any),
    .dly_sel   (dly_sel_i),
    .rst_act_o (rst_act)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[C_EXT] = ext_hit;
    set_vec[C_BOD] = bod_hit;
    set_vec[C_WDT] = wdt_hit;
  end

  rstsup_cause_reg u_cause (
    .clk     (clk),
    .por     (por_flag_i),
    .set_vec (set_vec),
    .wr      (reg_wr_i),
    .wdata   (reg_wdata_i),
    .flags_o (reg_rdata_o)
  );

  assign port_rst_n_o = ~src_any;
  assign sys_rst_n_o  = ~rst_act;

  // R2
  port_implies_sys_chk: assert property (@(posedge clk) disable iff (por_flag_i)
    !port_rst_n_o |-> !sys_rst_n_o);

  // R6
  wdt_gate_chk: assert property (@(posedge clk) disable iff (por_flag_i)
    (wdt_expire_i && (wdt_irq_mode_i || !wdt_en_i) && !ext_hit && !bod_hit) |-> port_rst_n_o);

  // R7
  bod_gate_chk: assert property (@(posedge clk) disable iff (por_flag_i)
    (bod_low_i && !bod_en_i && !ext_hit && !wdt_hit) |-> port_rst_n_o);
endmodule

// File: tb/reset_supervisor_tb.sv
module reset_supervisor_tb;
  localparam int MIN_W = 4;
  localparam int BASE  = 4;

  logic clk = 1'b0;
  logic por = 1'b0, ext_n = 1'b1, wdt_x = 1'b0, wdt_en = 1'b0, wdt_irq = 1'b0;
  logic bod_low = 1'b0, bod_en = 1'b0, wr = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [3:0] wdata = 4'h0;
  logic [3:0] rdata;
  logic sys_n, port_n;
  logic saw_rst = 1'b0;
  int vec = 0, bad = 0;

  always #10 clk = ~clk;

  reset_supervisor #(.MIN_W(MIN_W), .BASE_CYC(BASE), .SEL_W(2)) u_dut (
    .clk(clk), .por_flag_i(por), .ext_rst_n_i(ext_n), .wdt_expire_i(wdt_x),
    .wdt_en_i(wdt_en), .wdt_irq_mode_i(wdt_irq), .bod_low_i(bod_low), .bod_en_i(bod_en),
    .dly_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sys_rst_n_o(sys_n), .port_rst_n_o(port_n)
  );

  always @(posedge clk) if (sys_n !== 1'b1) saw_rst <= 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // count rising edges from now until sys reset is released
  task automatic wait_release(output int k);
    k = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      k++;
      if (sys_n === 1'b1) break;
    end
    @(negedge clk);
  endtask

  task automatic sw_write(input logic [3:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog timeout");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int k;
    #1 por = 1'b1;
    #1;
    chk("R2 por async port", 32'(port_n), 0);
    chk("R2 por async sys", 32'(sys_n), 0);
    idle(3);
    chk("R1 por sys", 32'(sys_n), 0);
    chk("R8 por value", 32'(rdata), 32'h1);
    por = 1'b0;
    wait_release(k);
    chk("R3 por release sel0", k, BASE);

    // R3 R7 sweep of delay select via brown-out
    bod_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      bod_low = 1'b1;
      #1;
      chk("R2 bod async port", 32'(port_n), 0);
      chk("R2 bod async sys", 32'(sys_n), 0);
      idle(3);
      bod_low = 1'b0;
      wait_release(k);
      chk("R3 release length", k, BASE << s);
      chk("R7 bod flag", 32'(rdata[2]), 1);
    end

    // R4 restart mid count
    sel = 2'd2;
    bod_low = 1'b1; idle(2); bod_low = 1'b0;
    idle(5);
    chk("R4 still stretched", 32'(sys_n), 0);
    bod_low = 1'b1; idle(1); bod_low = 1'b0;
    wait_release(k);
    chk("R4 restart full", k, BASE << 2);
    sel = 2'd0;

    // R9 write zero clears, write one no effect
    sw_write(4'h0);
    chk("R9 clear all", 32'(rdata), 0);
    sw_write(4'hF);
    chk("R9 write ones", 32'(rdata), 0);

    // R7 disabled brown-out ignored
    bod_en = 1'b0; saw_rst = 1'b0;
    bod_low = 1'b1; idle(4);
    chk("R7 disabled port", 32'(port_n), 1);
    bod_low = 1'b0; idle(2);
    chk("R7 disabled no reset", 32'(saw_rst), 0);
    chk("R7 disabled no flag", 32'(rdata), 0);

    // R5 pulse width sweep
    for (int w = 1; w <= MIN_W + 2; w++) begin
      sw_write(4'h0);
      saw_rst = 1'b0;
      ext_n = 1'b0; idle(w); ext_n = 1'b1;
      idle(20);
      chk("R5 ext flag", 32'(rdata[1]), (w >= MIN_W) ? 1 : 0);
      chk("R5 ext reset seen", 32'(saw_rst), (w >= MIN_W) ? 1 : 0);
    end
    ext_n = 1'b0; idle(MIN_W + 4); ext_n = 1'b1;
    wait_release(k);
    chk("R5 ext release", k, BASE + 3);

    // R6 watchdog gating, all four combinations
    for (int c = 0; c < 4; c++) begin
      sw_write(4'h0);
      saw_rst = 1'b0;
      wdt_en = c[0]; wdt_irq = c[1];
      wdt_x = 1'b1; idle(1); wdt_x = 1'b0;
      idle(12);
      chk("R6 wdt flag", 32'(rdata[3]), (c == 1) ? 1 : 0);
      chk("R6 wdt reset", 32'(saw_rst), (c == 1) ? 1 : 0);
    end
    wdt_en = 1'b1; wdt_irq = 1'b0;
    wdt_x = 1'b1; idle(1); wdt_x = 1'b0;
    wait_release(k);
    chk("R1 R3 wdt release", k, BASE);

    // R8 non-power-on sources accumulate
    sw_write(4'h0);
    bod_en = 1'b1; bod_low = 1'b1; idle(2); bod_low = 1'b0; idle(10);
    wdt_x = 1'b1; idle(1); wdt_x = 1'b0; idle(10);
    chk("R8 accumulate", 32'(rdata), 32'hC);
    ext_n = 1'b0; idle(MIN_W + 3); ext_n = 1'b1; idle(12);
    chk("R8 accumulate ext", 32'(rdata), 32'hE);

    // R10 set versus clear in one cycle
    @(negedge clk); wr = 1'b1; wdata = 4'h0; wdt_x = 1'b1;
    @(posedge clk); #1;
    chk("R10 set wins", 32'(rdata), 32'h8);
    @(negedge clk); wr = 1'b0; wdt_x = 1'b0;
    idle(10);

    // R8 power-on overrides older flags
    chk("R8 before por", 32'(rdata), 32'h8);
    por = 1'b1; #1;
    chk("R8 por async", 32'(rdata), 32'h1);
    idle(2); por = 1'b0;
    wait_release(k);
    chk("R8 por after", 32'(rdata), 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule